// File: doc/BRIEF.md
# ULPI Link-Side Bus Controller

This block sits on the link-layer side of an 8-bit ULPI connection to a USB PHY. Every signal is registered or sampled on the rising edge of the 60 MHz clock that the PHY supplies. The PHY decides who owns the shared data bus through DIR. While DIR is high, the block only listens: it captures the bytes the PHY drives and hands them to the link logic with a flag that copies NXT. While DIR is low, the block drives the bus. It drives zero when it has nothing to send. It can also drive one of two kinds of outbound transfer.

The first kind is a transmit packet, taken one byte at a time from an upstream stream with valid, last and ready signals. The second is a register write, built from an address and a data byte. The PHY accepts each byte by raising NXT, and the block finishes every transfer with a single-cycle STP. The bus is never driven in the cycle that follows a change of DIR. The bus is also held released from reset until the PHY first lowers DIR, which covers the PHY's clock start-up.

If DIR rises while a transfer is in progress, the transfer is dropped and the block signals an abort. For a packet, the upstream side then offers the whole packet again. A pending register write simply stays requested. A typical register write is the transceiver reset: bit 5 written at address 04h.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: While reset is held and after it ends, ulpiDataOe and ulpiStp are low. The block treats the PHY as the bus owner at reset, so the earliest cycle in which it may drive is the second consecutive cycle with DIR low.
- R2: ulpiDataOe is high exactly when DIR is low in the current cycle and was low at the previous clock edge. Outside a transfer the driven byte is 00h.
- R3: A transfer starts only from idle, at an edge where ulpiDataOe is high. A pending register write wins over a pending packet. When a packet starts, txReady is high in that cycle, and the first byte (which must be non-zero) appears on the bus in the next cycle.
- R4: While a packet byte is on the bus, DIR is low and NXT is low, the byte is held unchanged and txReady stays low.
- R5: While a packet byte that is not the last is on the bus, DIR is low and NXT is high, txReady is high and the next upstream byte is on the bus in the following cycle.
- R6: When NXT accepts the last packet byte, or when a register data byte has been on the bus for its cycle, ulpiStp is high for exactly the next cycle with the bus at 00h. The block is idle after that cycle, and DIR has no effect during the STP cycle.
- R7: A register write puts {2'b10, regAddr[5:0]} on the bus until NXT is high. It then puts regData on the bus for one cycle, without waiting for NXT, and then STP follows. regAck is high during that STP cycle.
- R8: If DIR is high at an edge while a packet or register write is in progress (outside the STP cycle), the transfer is dropped. xferAbort is high for the one following cycle and the block returns to idle, with no STP. An aborted packet is taken again from its first byte, and an aborted register write remains pending.
- R9: If DIR was high at two consecutive edges, the cycle after the second edge has rxValid high, rxData equal to the bus byte sampled at that edge, and rxIsData equal to the NXT sampled there. Otherwise rxValid and rxIsData are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz clock from the PHY |
| rstN | input | 1 | Active-low synchronous reset |
| ulpiDir | input | 1 | Bus ownership from the PHY (high: PHY drives) |
| ulpiNxt | input | 1 | PHY byte-accept / receive-data flag |
| ulpiDataIn | input | 8 | Bus value driven by the PHY |
| ulpiDataOut | output | 8 | Byte the link drives onto the bus |
| ulpiDataOe | output | 1 | Output enable for ulpiDataOut |
| ulpiStp | output | 1 | End-of-transfer strobe to the PHY |
| txData | input | 8 | Upstream packet byte |
| txValid | input | 1 | Upstream byte available |
| txLast | input | 1 | Upstream byte is the last of its packet |
| txReady | output | 1 | Upstream byte taken at this edge |
| regReq | input | 1 | Register write pending |
| regAddr | input | 6 | Register address |
| regData | input | 8 | Register write value |
| regAck | output | 1 | Register write finished (one cycle) |
| xferAbort | output | 1 | Current transfer dropped by DIR (one cycle) |
| rxData | output | 8 | Byte captured from the PHY |
| rxValid | output | 1 | rxData is valid this cycle |
| rxIsData | output | 1 | Captured byte was sampled with NXT high |

## Verification
The bench first runs packets and register writes with DIR low and NXT always high. This tests the exact byte order, the ready pulses and the STP placement, with no stalls to hide an off-by-one error. A held DIR after reset then tests the start-up hold-off and the first turnaround cycle. Random NXT stalls without preemption separate holding a byte from advancing past it. Random DIR bursts that land in every phase of a transfer, including a command or data byte and the STP cycle, separate a clean abort-and-retry from a lost or repeated byte. A register write and a packet requested together test the priority rule.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_CMD,
    ST_REGDATA,
    ST_STOP
  } linkState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadTx;      // take upstream byte onto the bus
    logic loadCmd;     // put register-write command, latch data
    logic loadRegData; // put latched register data
    logic clearOut;    // return bus byte to idle zero
  } dpStrobe_t;

endpackage

// File: rtl/ulpi_link_dp.sv
module ulpi_link_dp
  import ulpi_link_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] txData,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regData,
  input  logic              ulpiDir,
  input  logic              ulpiNxt,
  input  logic [DATA_W-1:0] ulpiDataIn,
  output logic              busFree,
  output logic [DATA_W-1:0] outByte,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxIsData
);

  localparam int PREFIX_W = DATA_W - ADDR_W;
  localparam logic [PREFIX_W-1:0] CMD_WRITE = {1'b1, {(PREFIX_W-1){1'b0}}};

  logic              dirQ;
  logic [DATA_W-1:0] regDataHold;

  // the link may drive only after DIR was low at the previous edge too
  assign busFree = !ulpiDir && !dirQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ        <= 1'b1;  // PHY owns the bus until it first lowers DIR
      outByte     <= '0;
      regDataHold <= '0;
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxIsData    <= 1'b0;
    end else begin
      dirQ <= ulpiDir;
      if (strobe.clearOut)         outByte <= '0;
      else if (strobe.loadTx)      outByte <= txData;
      else if (strobe.loadCmd)     outByte <= {CMD_WRITE, regAddr};
      else if (strobe.loadRegData) outByte <= regDataHold;
      if (strobe.loadCmd) regDataHold <= regData;
      rxValid  <= ulpiDir && dirQ;
      rxIsData <= ulpiDir && dirQ && ulpiNxt;
      if (ulpiDir && dirQ) rxData <= ulpiDataIn;
    end
  end

  AST_RX_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(ulpiDir)); // R9

endmodule

// File: rtl/ulpi_link_fsm.sv
module ulpi_link_fsm
  import ulpi_link_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busFree,
  input  logic       ulpiDir,
  input  logic       ulpiNxt,
  input  logic       txValid,
  input  logic       txLast,
  input  logic       regReq,
  output dpStrobe_t  strobe,
  output logic       txReady,
  output linkState_t state,
  output logic       ulpiStp,
  output logic       xferAbort,
  output logic       regAck
);

  linkState_t stateNext;
  logic       lastQ, lastNext;
  logic       abortSet, ackSet;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    txReady   = 1'b0;
    lastNext  = lastQ;
    abortSet  = 1'b0;
    ackSet    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (busFree) begin
          if (regReq) begin
            strobe.loadCmd = 1'b1;
            stateNext      = ST_CMD;
          end else if (txValid) begin
            strobe.loadTx = 1'b1;
            txReady       = 1'b1;
            lastNext      = txLast;
            stateNext     = ST_TX;
          end
        end
      end
      ST_TX: begin
        if (ulpiDir) begin
          strobe.clearOut = 1'b1;
          abortSet        = 1'b1;
          stateNext       = ST_IDLE;
        end else if (ulpiNxt) begin
          if (lastQ) begin
            strobe.clearOut = 1'b1;
            stateNext       = ST_STOP;
          end else begin
            strobe.loadTx = 1'b1;
            txReady       = 1'b1;
            lastNext      = txLast;
          end
        end
      end
      ST_CMD: begin
        if (ulpiDir) begin
          strobe.clearOut = 1'b1;
          abortSet        = 1'b1;
          stateNext       = ST_IDLE;
        end else if (ulpiNxt) begin
          strobe.loadRegData = 1'b1;
          stateNext          = ST_REGDATA;
        end
      end
      ST_REGDATA: begin
        strobe.clearOut = 1'b1;
        if (ulpiDir) begin
          abortSet  = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          ackSet    = 1'b1;
          stateNext = ST_STOP;
        end
      end
      ST_STOP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      lastQ     <= 1'b0;
      xferAbort <= 1'b0;
      regAck    <= 1'b0;
    end else begin
      state     <= stateNext;
      lastQ     <= lastNext;
      xferAbort <= abortSet;
      regAck    <= ackSet;
    end
  end

  assign ulpiStp = (state == ST_STOP);

  AST_STP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ulpiStp |=> !ulpiStp); // R6

  AST_START_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !busFree) |=> state == ST_IDLE); // R3

  AST_ABORT_ON_DIR: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_TX || state == ST_CMD || state == ST_REGDATA) && ulpiDir)
    |=> (xferAbort && state == ST_IDLE)); // R8

endmodule

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl
  import ulpi_link_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ulpiDir,
  input  logic              ulpiNxt,
  input  logic [DATA_W-1:0] ulpiDataIn,
  output logic [DATA_W-1:0] ulpiDataOut,
  output logic              ulpiDataOe,
  output logic              ulpiStp,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  input  logic              txLast,
  output logic              txReady,
  input  logic              regReq,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regData,
  output logic              regAck,
  output logic              xferAbort,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxIsData
);

  localparam int PREFIX_W = DATA_W - ADDR_W;

  dpStrobe_t  strobe;
  linkState_t state;
  logic       busFree;

  ulpi_link_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .busFree   (busFree),
    .ulpiDir   (ulpiDir),
    .ulpiNxt   (ulpiNxt),
    .txValid   (txValid),
    .txLast    (txLast),
    .regReq    (regReq),
    .strobe    (strobe),
    .txReady   (txReady),
    .state     (state),
    .ulpiStp   (ulpiStp),
    .xferAbort (xferAbort),
    .regAck    (regAck)
  );

  ulpi_link_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txData     (txData),
    .regAddr    (regAddr),
    .regData    (regData),
    .ulpiDir    (ulpiDir),
    .ulpiNxt    (ulpiNxt),
    .ulpiDataIn (ulpiDataIn),
    .busFree    (busFree),
    .outByte    (ulpiDataOut),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .rxIsData   (rxIsData)
  );

  assign ulpiDataOe = busFree;

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX && !ulpiDir && !ulpiNxt) |=> $stable(ulpiDataOut)); // R4

  AST_CMD_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD) |-> ulpiDataOut[DATA_W-1:ADDR_W] == {1'b1, {(PREFIX_W-1){1'b0}}}); // R7

  AST_STOP_IDLE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    ulpiStp |-> ulpiDataOut == '0); // R6

  AST_ACK_WITH_STP: assert property (@(posedge clk) disable iff (!rstN)
    regAck |-> ulpiStp); // R7

endmodule

// File: tb/ulpi_link_ctrl_tb.sv
module ulpi_link_ctrl_tb;

  localparam int CLK_PERIOD = 16;
  localparam int NPKT       = 24;
  localparam int MAXLEN     = 8;
  localparam int NREG       = 6;
  localparam int MAXCYC     = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ulpiDir = 1'b1, ulpiNxt = 1'b0;
  logic [7:0] ulpiDataIn = '0;
  logic [7:0] ulpiDataOut;
  logic       ulpiDataOe, ulpiStp;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0, txLast = 1'b0, txReady;
  logic       regReq = 1'b0;
  logic [5:0] regAddr = '0;
  logic [7:0] regData = '0;
  logic       regAck, xferAbort;
  logic [7:0] rxData;
  logic       rxValid, rxIsData;

  always #(CLK_PERIOD/2) clk = ~clk;

  ulpi_link_ctrl u_dut (
    .clk(clk), .rstN(rstN), .ulpiDir(ulpiDir), .ulpiNxt(ulpiNxt),
    .ulpiDataIn(ulpiDataIn), .ulpiDataOut(ulpiDataOut), .ulpiDataOe(ulpiDataOe),
    .ulpiStp(ulpiStp), .txData(txData), .txValid(txValid), .txLast(txLast),
    .txReady(txReady), .regReq(regReq), .regAddr(regAddr), .regData(regData),
    .regAck(regAck), .xferAbort(xferAbort), .rxData(rxData), .rxValid(rxValid),
    .rxIsData(rxIsData)
  );

  int vectors = 0;
  int fails   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] pktMem [NPKT*MAXLEN];
  int         pktLen [NPKT];
  logic [5:0] regA   [NREG];
  logic [7:0] regD   [NREG];

  initial begin
    // stimulus data
    for (int p = 0; p < NPKT; p++) begin
      pktLen[p] = 1 + ((p * 5 + 3) % MAXLEN);
      for (int b = 0; b < MAXLEN; b++)
        pktMem[p*MAXLEN+b] = (b == 0) ? (8'h40 | 8'(p & 15)) : 8'($urandom);
    end
    regA[0] = 6'h04; regD[0] = 8'h20;  // transceiver reset write
    for (int r = 1; r < NREG; r++) begin
      regA[r] = 6'($urandom); regD[r] = 8'($urandom);
    end
  end

  initial begin
    int  pIdx = 0, rIdx = 0, cur = 0, upPos = 0, done = 0;
    int  mBusy = 0;      // 0 idle, 1 packet, 2 reg command, 3 reg data
    bit  mStop = 1'b0;
    bit  prevDir = 1'b1;
    int  dirCnt = 0;
    int  dirPct, nxtPct;
    int  cyc = 0;
    bit  expReady, expAbort, expAck, expOe, nStop, doneTx, doneReg, abortTx;
    bit  expRxV, expRxD;
    logic [7:0] expRxByte;
    int  nBusy;

    // reset: PHY holds DIR high
    repeat (3) @(posedge clk);
    #1;
    chk(!ulpiDataOe, "R1 reset oe", ulpiDataOe, 0);
    chk(!ulpiStp, "R1 reset stp", ulpiStp, 0);
    chk(!xferAbort && !regAck && !rxValid, "R1 reset flags", {xferAbort, regAck, rxValid}, 0);
    rstN = 1'b1;

    while (!(pIdx == NPKT && rIdx == NREG && mBusy == 0 && !mStop) && cyc < MAXCYC) begin
      // phase choice: start-up hold-off, clean runs, then random stalls/preemption
      if (cyc < 6)        begin dirPct = 100; nxtPct = 100; end
      else if (done < 3)  begin dirPct = 0;   nxtPct = 100; end
      else if (done < 8)  begin dirPct = 0;   nxtPct = 50;  end
      else                begin dirPct = 12;  nxtPct = 55;  end

      if (dirCnt > 0) begin ulpiDir = 1'b1; dirCnt--; end
      else if (int'($urandom % 100) < dirPct) begin ulpiDir = 1'b1; dirCnt = int'($urandom % 4); end
      else ulpiDir = 1'b0;
      ulpiNxt    = (int'($urandom % 100) < nxtPct);
      ulpiDataIn = 8'($urandom);

      txValid = (pIdx < NPKT) && (upPos < pktLen[pIdx]);
      txData  = (pIdx < NPKT && upPos < MAXLEN) ? pktMem[pIdx*MAXLEN+upPos] : 8'h00;
      txLast  = (pIdx < NPKT) && (upPos == pktLen[pIdx] - 1);
      regReq  = (rIdx < NREG);
      regAddr = (rIdx < NREG) ? regA[rIdx] : 6'h00;
      regData = (rIdx < NREG) ? regD[rIdx] : 8'h00;
      #1;

      expOe = !ulpiDir && !prevDir;
      chk(ulpiDataOe == expOe, "R2 output enable", ulpiDataOe, expOe);
      chk(ulpiStp == mStop, "R6 stp level", ulpiStp, mStop);
      if (mStop && ulpiDataOe) chk(ulpiDataOut == 8'h00, "R6 bus zero at stp", ulpiDataOut, 0);
      if (!mStop && mBusy == 0 && ulpiDataOe)
        chk(ulpiDataOut == 8'h00, "R2 idle byte", ulpiDataOut, 0);

      expReady = 0; expAbort = 0; expAck = 0; nStop = 0; doneTx = 0; doneReg = 0; abortTx = 0;
      nBusy = mBusy;
      if (!mStop) begin
        case (mBusy)
          0: if (expOe) begin
               if (regReq) nBusy = 2;          // R3 register write first
               else if (txValid) begin nBusy = 1; expReady = 1; end
             end
          1: begin
               if (ulpiDataOe)
                 chk(ulpiDataOut == pktMem[pIdx*MAXLEN+cur], "R4 R5 packet byte",
                     ulpiDataOut, pktMem[pIdx*MAXLEN+cur]);
               if (ulpiDir) begin expAbort = 1; nBusy = 0; abortTx = 1; end
               else if (ulpiNxt) begin
                 if (cur == pktLen[pIdx] - 1) begin nStop = 1; nBusy = 0; doneTx = 1; end
                 else expReady = 1;
               end
             end
          2: begin
               if (ulpiDataOe)
                 chk(ulpiDataOut == {2'b10, regA[rIdx]}, "R7 command byte",
                     ulpiDataOut, {2'b10, regA[rIdx]});
               if (ulpiDir) begin expAbort = 1; nBusy = 0; end
               else if (ulpiNxt) nBusy = 3;
             end
          default: begin
               if (ulpiDataOe)
                 chk(ulpiDataOut == regD[rIdx], "R7 data byte", ulpiDataOut, regD[rIdx]);
               if (ulpiDir) begin expAbort = 1; nBusy = 0; end
               else begin nStop = 1; nBusy = 0; expAck = 1; doneReg = 1; end
             end
        endcase
      end
      chk(txReady == expReady, "R3 R4 R5 txReady", txReady, expReady);
      expRxV    = ulpiDir && prevDir;
      expRxD    = ulpiDir && prevDir && ulpiNxt;
      expRxByte = ulpiDataIn;

      @(posedge clk);
      #1;
      chk(xferAbort == expAbort, "R8 abort pulse", xferAbort, expAbort);
      chk(regAck == expAck, "R7 regAck", regAck, expAck);
      chk(rxValid == expRxV, "R9 rxValid", rxValid, expRxV);
      chk(rxIsData == expRxD, "R9 rxIsData", rxIsData, expRxD);
      if (expRxV) chk(rxData == expRxByte, "R9 rxData", rxData, expRxByte);

      if (expReady) begin cur = upPos; upPos++; end
      if (abortTx) begin upPos = 0; cur = 0; end
      if (doneTx) begin pIdx++; upPos = 0; cur = 0; done++; end
      if (doneReg) begin rIdx++; done++; end
      mBusy   = nBusy;
      mStop   = nStop;
      prevDir = ulpiDir;
      cyc++;
    end

    chk(cyc < MAXCYC, "R3 watchdog", cyc, MAXCYC);
    chk(pIdx == NPKT, "R5 R8 packets delivered", pIdx, NPKT);
    chk(rIdx == NREG, "R7 R8 register writes delivered", rIdx, NREG);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule